// File: doc/BRIEF.md
# SPI Flash Word Read Engine

This engine fetches a contiguous region of a serial NOR flash into a 32-bit word stream. A caller presents a 24-bit byte offset and a byte length, then pulses `start`. The engine drives chip select low and shifts out one 32-bit command word: the read opcode in the top byte and the flash address below it. Once that word has fully left the shifter, the data phase begins. During the data phase the transmit side feeds all-ones filler words only to keep the serial clock running, and the receive side gathers 32 bits per word into a small FIFO. From there each word leaves on a valid/ready stream, reversed in byte order if the caller asked for that.

A long request is split into chunks of at most `CHUNK_BYTES`. Before each chunk, the filler and receive FIFOs return to empty and a packet counter is loaded with the chunk's word count. The serial clock runs at the system clock divided by `DIV` in SPI mode 0. Whenever the receive FIFO has no room for another word, the serial clock simply stops between words, so backpressure never loses data.

Top module: `spi_word_reader`

## Requirements
- R1: The first 32 bits on `mosi` after `cs_n` falls are taken on rising `sclk` edges, MSB first. They are 0x03 followed by `offset[23:0]`.
- R2: `cs_n` is low from before the first rising `sclk` edge until after the last data bit. It falls exactly once per accepted request and is high whenever the engine is idle.
- R3: The data phase starts only after all 32 bits of the command word are sent. The `miso` bits taken on the rising edges after the 32nd form the data. In a word without swap, the first byte received sits in bits 31:24.
- R4: A length of zero, or one that is not a multiple of 4, is rejected. `err` and `done` pulse together one cycle after `start`, and `sclk` and `cs_n` do not move.
- R5: A request of `length` bytes produces exactly 32 + 8*`length` rising `sclk` edges, however it is split into chunks. The FIFO reset between chunks loses no data.
- R6: During the data phase `mosi` is 1 on every rising `sclk` edge. The filler FIFO never holds more than `TX_CAP` bytes.
- R7: `sclk` is low whenever `cs_n` is high and between words. Data is sampled on the rising edge and shifted on the falling edge.
- R8: If `swap_en` was 1 when the request was accepted, the received bytes b0..b3 (in arrival order) are output as {b3,b2,b1,b0}. If it was 0, they are output as {b0,b1,b2,b3}.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. At most `RX_DEPTH` words are buffered, after which `sclk` stops.
- R10: `done` is a one-cycle pulse that comes after `cs_n` has returned high.
- R11: A `start` that arrives while `busy` is high has no effect.
- R12: Exactly `length`/4 words are output, in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| offset | input | 24 | Flash byte address of the first byte |
| length | input | LEN_W | Byte count; must be a nonzero multiple of 4 |
| swap_en | input | 1 | Reverse byte order of output words |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| out_data | output | 32 | Received word |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Consumer accepts the word |

## Verification
The bench sweeps every legal length across one, several and partial chunks, with and without swap, under steady and intermittent `out_ready`. A design that miscounted the packet limit would show extra or missing clock edges, and one that dropped words at a chunk FIFO reset would output the wrong word count. A long `out_ready` hold must freeze the edge count at exactly the command word plus a full FIFO; a design without stalling would run on and lose words. Odd and zero lengths, and a `start` issued mid-transfer, must leave the bus untouched and the transfer in progress intact.

// File: rtl/spi_word_reader.sv
module spi_word_reader #(
  parameter int DIV         = 4,
  parameter int LEN_W       = 24,
  parameter int CHUNK_BYTES = 32768,
  parameter int RX_DEPTH    = 8,
  parameter int TX_CAP      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      offset,
  input  logic [LEN_W-1:0] length,
  input  logic             swap_en,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic [31:0]      out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int HALF = DIV / 2;
  localparam int HW   = $clog2(HALF) + 1;
  localparam int RAW  = $clog2(RX_DEPTH);
  localparam int TLW  = $clog2(TX_CAP + 4) + 1;
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);
  localparam logic [LEN_W-1:0] FOUR_L  = LEN_W'(4);
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);
  localparam logic [RAW:0]     RX_FULL = (RAW+1)'(RX_DEPTH);
  localparam logic [TLW-1:0]   TX_LIM  = TLW'(TX_CAP);
  localparam logic [TLW-1:0]   TX_WORD = TLW'(4);
  localparam logic [HW-1:0]    H_END   = HW'(HALF - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_LOAD, S_DATA, S_END, S_FIN} st_t;

  st_t              st;
  logic [LEN_W-1:0] rem, pkt_cnt, out_left, in_left;
  logic [TLW-1:0]   tx_lvl;
  logic             swap_q, cs_q, done_q, err_q;

  logic             act, sclk_q;
  logic [HW-1:0]    hcnt;
  logic [5:0]       bits;
  logic [31:0]      sh_o, sh_i;

  logic [31:0]      mem [RX_DEPTH];
  logic [RAW-1:0]   wp, rp;
  logic [RAW:0]     rx_cnt;

  logic             tick, wdone, len_ok, cmd_go, data_go, q_tx, push, pop;
  logic [LEN_W-1:0] chunk;
  logic [31:0]      raw;

  assign tick    = act && (hcnt == H_END);
  assign wdone   = tick && sclk_q && (bits == 6'd32);
  assign len_ok  = (length != '0) && (length[1:0] == 2'b00);
  assign cmd_go  = (st == S_IDLE) && start && len_ok;
  assign data_go = (st == S_DATA) && !act && (pkt_cnt != '0) &&
                   (tx_lvl >= TX_WORD) && (rx_cnt < RX_FULL);
  assign q_tx    = (st == S_DATA) && (out_left != '0) && (tx_lvl < TX_LIM);
  assign push    = wdone && (st == S_DATA);
  assign pop     = out_valid && out_ready;
  assign chunk   = (rem > CHUNK_L) ? CHUNK_L : rem;

  assign raw       = mem[rp];
  assign out_data  = swap_q ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
  assign out_valid = (rx_cnt != '0);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = act ? sh_o[31] : 1'b0;

  // serial word shifter: mode 0, one 32-bit word per activation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      sclk_q <= 1'b0;
      hcnt   <= '0;
      bits   <= '0;
      sh_o   <= '0;
      sh_i   <= '0;
    end else if (cmd_go || data_go) begin
      act    <= 1'b1;
      sclk_q <= 1'b0;
      hcnt   <= '0;
      bits   <= '0;
      sh_o   <= cmd_go ? {8'h03, offset} : 32'hFFFF_FFFF;
    end else if (act) begin
      if (tick) begin
        hcnt   <= '0;
        sclk_q <= !sclk_q;
        if (!sclk_q) begin
          sh_i <= {sh_i[30:0], miso};
          bits <= bits + 6'd1;
        end else if (bits == 6'd32) begin
          act <= 1'b0;
        end else begin
          sh_o <= {sh_o[30:0], 1'b0};
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  // request sequencing, chunking and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      pkt_cnt  <= '0;
      out_left <= '0;
      in_left  <= '0;
      swap_q   <= 1'b0;
      cs_q     <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (len_ok) begin
            cs_q   <= 1'b0;
            rem    <= length;
            swap_q <= swap_en;
            st     <= S_CMD;
          end else begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        S_CMD: if (wdone) st <= S_LOAD;
        S_LOAD: begin
          pkt_cnt  <= chunk >> 2;
          out_left <= chunk;
          in_left  <= chunk;
          rem      <= rem - chunk;
          st       <= S_DATA;
        end
        S_DATA: begin
          if (data_go) pkt_cnt  <= pkt_cnt - ONE_L;
          if (q_tx)    out_left <= out_left - FOUR_L;
          if (pop)     in_left  <= in_left - FOUR_L;
          if (in_left == '0) st <= (rem == '0) ? S_END : S_LOAD;
        end
        S_END: begin
          cs_q <= 1'b1;
          st   <= S_FIN;
        end
        S_FIN: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // filler level and receive FIFO, both cleared at each chunk start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lvl <= '0;
      wp     <= '0;
      rp     <= '0;
      rx_cnt <= '0;
    end else if (st == S_LOAD) begin
      tx_lvl <= '0;
      wp     <= '0;
      rp     <= '0;
      rx_cnt <= '0;
    end else begin
      case ({q_tx, data_go})
        2'b10:   tx_lvl <= tx_lvl + TX_WORD;
        2'b01:   tx_lvl <= tx_lvl - TX_WORD;
        default: tx_lvl <= tx_lvl;
      endcase
      if (push) wp <= wp + RAW'(1);
      if (pop)  rp <= rp + RAW'(1);
      case ({push, pop})
        2'b10:   rx_cnt <= rx_cnt + (RAW+1)'(1);
        2'b01:   rx_cnt <= rx_cnt - (RAW+1)'(1);
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= sh_i;
  end
endmodule

// File: rtl/spi_word_reader_chk.sv
module spi_word_reader_chk #(
  parameter int RX_DEPTH = 8,
  parameter int TX_CAP   = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cs_n,
  input logic                             sclk,
  input logic                             busy,
  input logic                             done,
  input logic                             err,
  input logic                             out_valid,
  input logic                             out_ready,
  input logic [31:0]                      out_data,
  input logic [$clog2(TX_CAP+4):0]        tx_lvl,
  input logic [$clog2(RX_DEPTH):0]        rx_cnt
);
  AST_IDLE_CS:  assert property (@(posedge clk) disable iff (!rst_n) (!busy) |-> cs_n);           // R2
  AST_CLK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);             // R7
  AST_TX_CAP:   assert property (@(posedge clk) disable iff (!rst_n) tx_lvl <= TX_CAP);           // R6
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= RX_DEPTH);         // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                  (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));                // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);           // R10
  AST_ERR_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) err |-> (cs_n && done && !busy)); // R4
endmodule

bind spi_word_reader spi_word_reader_chk #(.RX_DEPTH(RX_DEPTH), .TX_CAP(TX_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done),
  .err(err), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tx_lvl(tx_lvl), .rx_cnt(rx_cnt)
);

// File: tb/sim_spi_word_reader.sv
module sim_spi_word_reader;
  localparam int CLK_P = 10;
  localparam int LW    = 12;
  localparam int DEPTH = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, swap_en = 1'b0, out_ready = 1'b1, miso = 1'b0;
  logic [23:0] offset = '0;
  logic [LW-1:0] length = '0;
  logic busy, done, err, sclk, cs_n, mosi, out_valid;
  logic [31:0] out_data;

  int checks = 0, fails = 0;
  int rmode = 0, cyc = 0;
  int ngot = 0, ndone = 0, nerr = 0, cs_bad = 0;
  int edges = 0, mosi_bad = 0, csfall = 0, fcnt = 0;
  logic [31:0] fcmd = '0;
  logic [31:0] got [64];

  always #(CLK_P/2) clk = ~clk;

  spi_word_reader #(.DIV(4), .LEN_W(LW), .CHUNK_BYTES(16), .RX_DEPTH(DEPTH), .TX_CAP(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .length(length),
    .swap_en(swap_en), .busy(busy), .done(done), .err(err), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready));

  function automatic logic [7:0] mbyte(input logic [23:0] a);
    logic [31:0] t;
    t = 32'(a) * 13 + 32'(a >> 5) + 32'h5A;
    return t[7:0];
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] off, input int k, input logic sw);
    logic [23:0] a;
    a = off + 24'(4 * k);
    if (sw) return {mbyte(a + 24'd3), mbyte(a + 24'd2), mbyte(a + 24'd1), mbyte(a)};
    return {mbyte(a), mbyte(a + 24'd1), mbyte(a + 24'd2), mbyte(a + 24'd3)};
  endfunction

  // flash model (mode 0)
  always @(negedge cs_n) begin fcnt = 0; csfall++; end
  always @(posedge sclk) begin
    edges++;
    if (!cs_n) begin
      if (fcnt < 32) fcmd = {fcmd[30:0], mosi};
      else if (mosi !== 1'b1) mosi_bad++;
      fcnt++;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && fcnt >= 32) begin
      logic [7:0] b;
      b = mbyte(fcmd[23:0] + 24'((fcnt - 32) / 8));
      miso = b[7 - ((fcnt - 32) % 8)];
    end
  end

  // ready driver and stream monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (rmode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      if (done) ndone++;
      if (err) nerr++;
      if (done && !cs_n) cs_bad++;
      if (out_valid && out_ready) begin
        if (ngot < 64) got[ngot] = out_data;
        ngot++;
        if (cs_n) cs_bad++;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [23:0] off, input int len, input logic sw);
    ngot = 0; ndone = 0; nerr = 0; edges = 0; mosi_bad = 0; csfall = 0; cs_bad = 0;
    @(negedge clk);
    offset = off; length = LW'(len); swap_en = sw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_read();
    while (ndone == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [23:0] off, input int len, input logic sw);
    chk(fcmd == {8'h03, off}, "R1 command word", fcmd, {8'h03, off});
    chk(csfall == 1 && cs_bad == 0 && cs_n, "R2 chip select", 32'(csfall), 32'd1);
    chk(edges == 32 + 8 * len, "R5 clock edge count", 32'(edges), 32'(32 + 8 * len));
    chk(mosi_bad == 0, "R6 filler ones", 32'(mosi_bad), 32'd0);
    chk(ndone == 1, "R10 single done", 32'(ndone), 32'd1);
    chk(ngot == len / 4, "R12 word count", 32'(ngot), 32'(len / 4));
    for (int k = 0; k < len / 4 && k < 64; k++)
      chk(got[k] == exp_word(off, k, sw), sw ? "R8 swapped word" : "R3 word order", got[k], exp_word(off, k, sw));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !out_valid && !done && !err, "R2 R7 reset state",
        {27'd0, cs_n, sclk, busy, out_valid, done}, 32'h10);

    // sweep lengths across one, several and partial chunks
    for (int pass = 0; pass < 2; pass++) begin
      rmode = pass;
      for (int len = 4; len <= 40; len += 4) begin
        logic [23:0] off;
        logic sw;
        off = 24'h0FF0 + 24'(len * 37 + pass * 5);
        sw  = ((len / 4 + pass) % 2) == 1;
        launch(off, len, sw);
        finish_read();
        verify(off, len, sw);
      end
    end
    rmode = 0;

    // rejected lengths
    foreach (length[i]) ;
    for (int t = 0; t < 3; t++) begin
      int bl;
      bl = (t == 0) ? 6 : (t == 1) ? 0 : 13;
      launch(24'h123, bl, 1'b0);
      repeat (6) @(negedge clk);
      chk(nerr == 1 && ndone == 1, "R4 reject pulse", 32'(nerr), 32'd1);
      chk(edges == 0 && csfall == 0 && cs_n, "R4 bus quiet", 32'(edges), 32'd0);
    end

    // start while busy is ignored
    launch(24'h100, 16, 1'b0);
    repeat (200) @(negedge clk);
    chk(busy, "R11 busy mid transfer", 32'(busy), 32'd1);
    offset = 24'h777; length = LW'(8); swap_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_read();
    chk(ngot == 4 && edges == 32 + 128 && csfall == 1, "R11 second start ignored", 32'(ngot), 32'd4);
    verify(24'h100, 16, 1'b0);

    // backpressure stalls the serial clock
    rmode = 2;
    launch(24'h40, 32, 1'b0);
    repeat (3000) @(negedge clk);
    chk(edges == 32 + 32 * DEPTH, "R9 clock stalls when full", 32'(edges), 32'(32 + 32 * DEPTH));
    chk(ngot == 0 && out_valid && out_data == exp_word(24'h40, 0, 1'b0), "R9 word held",
        out_data, exp_word(24'h40, 0, 1'b0));
    rmode = 0;
    finish_read();
    verify(24'h40, 32, 1'b0);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule